// File: doc/BRIEF.md
# Host Posted-Write Handshake Controller

This controller connects an asynchronous host port to a local-memory sequencer. The sequencer runs on a machine cycle of four clock phases, Q1 through Q4. Host access requests are sampled at one fixed point in that cycle. Each accepted request becomes a local-memory cycle that starts at the next Q1.

Writes are posted. As soon as the controller holds a write word in its one-entry buffer, it raises ready and the host may move on, while the memory write completes in the background. A second write that arrives while the first is still in memory is held off until the first finishes.

In implicit-addressing mode an internal address register steps by one word after each access. After such a write, the controller also prefetches the word at the new address into its read register.

Top module: `host_post_ctrl`

## Requirements
- R1: After reset the phase output is 0 (Q1), ready is low and all active-low strobes (`alatch_n`, `cas_n`, `hoe_n`, `we_n`) are high. The phase then advances 0,1,2,3,0 (Q1,Q2,Q3,Q4,Q1) on every clock.
- R2: A host strobe is `host_sel` together with `host_wr` or `host_rd`. It is sampled only on the clock edge that enters Q4 (phase 3). An accepted request drives `alatch_n` and `cas_n` low from the following Q1 through Q3. A strobe first raised during Q4 waits for the next Q4 entry, one full machine cycle later.
- R3: For a write cycle, ready rises at the start of Q2 of that cycle. At the same edge the write word is captured into the posted buffer, shown on `mem_wdata`, and `we_n` goes low for Q2 and Q3.
- R4: At Q4 every memory strobe is high again. `hoe_n` goes low only in host write cycles.
- R5: A second write requested while the first is still being written is not given ready before the first write's memory cycle has ended. Its own memory cycle begins at the next Q1, and its ready follows at Q2.
- R6: `ddin` is high from the Q4 in which a host write is accepted through Q3 of its memory cycle. It is low at Q4 after completion, and low in read and prefetch cycles.
- R7: Ready stays high while the host strobe is held and falls on the first edge after the strobe is dropped. A strobe held across several Q4 entries counts as one access.
- R8: `host_ald` loads `host_addr` into the address register, shown on `mem_addr`. A write accepted with `host_auto` high increments the address by one at its completing Q4 entry. With `host_auto` low the address is unchanged.
- R9: After an auto-increment write, and when no host request is pending, a prefetch read starts at the next Q1 at the incremented address. It has `cas_n` low, `hoe_n` and `we_n` high and `ddin` low. `host_rdata` takes `mem_rdata` at the Q4 entry that ends the prefetch, and the address does not change.
- R10: A host read runs a memory cycle at the current address. At the Q4 entry that ends it, ready rises and `host_rdata` takes `mem_rdata`. With `host_auto` high the address then increments by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock, one phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host chip select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_auto | input | 1 | Implicit addressing for this access |
| host_ald | input | 1 | Load address register |
| host_addr | input | AW | Address to load |
| host_wdata | input | DW | Host write word |
| host_rdy | output | 1 | Ready back to host |
| host_rdata | output | DW | Read / prefetched word |
| phase | output | 2 | Current phase, 0..3 = Q1..Q4 |
| ddin | output | 1 | Data direction in, high during host writes |
| alatch_n | output | 1 | Address latch strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| hoe_n | output | 1 | Host data latch output enable, active low |
| we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Posted write word to memory |
| mem_rdata | input | DW | Memory read word |

## Verification
The bench raises a strobe just after the Q4 sampling edge. A controller that samples in every phase would start the memory cycle one machine cycle too early.

It drops and reraises the write strobe while the first posted write is still in memory. A controller that ignores the in-flight buffer would grant ready before Q4 and overwrite the buffered word. It also holds a strobe over many Q4 entries, which a level-sensitive acceptor would turn into repeated memory cycles.

With implicit addressing, it checks the address step and the prefetch that follows it. An off-by-one increment or a prefetch that bumps the address again shows up on `mem_addr` and `host_rdata`.

// File: rtl/host_post_ctrl.sv
module host_post_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_auto,
  input  logic          host_ald,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_rdy,
  output logic [DW-1:0] host_rdata,
  output logic [1:0]    phase,
  output logic          ddin,
  output logic          alatch_n,
  output logic          cas_n,
  output logic          hoe_n,
  output logic          we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [1:0] Q1 = 2'd0, Q2 = 2'd1, Q3 = 2'd2, Q4 = 2'd3;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_PF = 2'd2;

  logic [1:0]    ph, kind;
  logic          seen, acc, acc_wr, acc_auto;
  logic          cyc, cyc_auto, pf_pend, wbuf_vld, rdy;
  logic [AW-1:0] addr;
  logic [DW-1:0] wbuf, rdata;

  wire strobe = host_sel & (host_wr | host_rd);
  wire samp   = (ph == Q3);
  wire start  = (ph == Q4);
  wire done   = cyc & (ph == Q3);
  wire wr_cyc = cyc & (kind == K_WR);
  wire grant  = wr_cyc & (ph == Q1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= Q1;
      seen     <= 1'b0;
      acc      <= 1'b0;
      acc_wr   <= 1'b0;
      acc_auto <= 1'b0;
      cyc      <= 1'b0;
      kind     <= K_WR;
      cyc_auto <= 1'b0;
      pf_pend  <= 1'b0;
      wbuf_vld <= 1'b0;
      wbuf     <= '0;
      rdata    <= '0;
      addr     <= '0;
      rdy      <= 1'b0;
    end else begin
      ph   <= ph + 2'd1;
      seen <= strobe & (seen | samp);
      rdy  <= strobe & (rdy | grant | (done & (kind == K_RD)));

      if (samp && strobe && !seen) begin
        acc      <= 1'b1;
        acc_wr   <= host_wr;
        acc_auto <= host_auto;
      end else if (start) begin
        acc <= 1'b0;
      end

      if (start && acc) begin
        cyc      <= 1'b1;
        kind     <= acc_wr ? K_WR : K_RD;
        cyc_auto <= acc_auto;
      end else if (start && pf_pend) begin
        cyc      <= 1'b1;
        kind     <= K_PF;
        cyc_auto <= 1'b0;
        pf_pend  <= 1'b0;
      end else if (done) begin
        cyc      <= 1'b0;
        wbuf_vld <= 1'b0;
        if (kind != K_WR) rdata <= mem_rdata;
        if (kind == K_WR && cyc_auto) pf_pend <= 1'b1;
      end

      if (grant) begin
        wbuf_vld <= 1'b1;
        wbuf     <= host_wdata;
      end

      if (host_ald) addr <= host_addr;
      else if (done && cyc_auto) addr <= addr + 1'b1;
    end
  end

  assign phase      = ph;
  assign host_rdy   = rdy;
  assign host_rdata = rdata;
  assign mem_addr   = addr;
  assign mem_wdata  = wbuf;
  assign ddin       = (acc & acc_wr) | wr_cyc;
  assign alatch_n   = ~cyc;
  assign cas_n      = ~cyc;
  assign hoe_n      = ~wr_cyc;
  assign we_n       = ~wbuf_vld;

  assert_cycle_starts_q1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> phase == Q1);
  assert_strobes_high_q4_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == Q4 |-> (cas_n && alatch_n && hoe_n && we_n));
  assert_wr_ready_q2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_rdy) && !we_n) |-> phase == Q2);
  assert_no_ready_while_posted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdy) |-> !$past(wbuf_vld));
  assert_ddin_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> ddin);
  assert_ready_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |-> $past(host_sel && (host_wr || host_rd)));
endmodule

// File: tb/test_host_post_ctrl.sv
module test_host_post_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 0, host_wr = 0, host_rd = 0, host_auto = 0, host_ald = 0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic        host_rdy, ddin, alatch_n, cas_n, hoe_n, we_n;
  logic [15:0] host_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  phase;
  int total = 0, bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;
  assign mem_rdata = mem_addr ^ 16'h5A5A;

  host_post_ctrl i_host_post_ctrl (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_auto(host_auto), .host_ald(host_ald), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdy(host_rdy), .host_rdata(host_rdata), .phase(phase), .ddin(ddin),
    .alatch_n(alatch_n), .cas_n(cas_n), .hoe_n(hoe_n), .we_n(we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic to_phase(logic [1:0] p);
    @(negedge clk);
    while (phase != p) @(negedge clk);
  endtask

  task automatic drop();
    host_sel = 0; host_wr = 0; host_rd = 0;
  endtask

  task automatic load_addr(logic [15:0] a);
    host_ald = 1; host_addr = a;
    step();
    host_ald = 0;
  endtask

  task automatic t_reset();
    chk("R1", "phase", phase, 0);
    chk("R1", "rdy", host_rdy, 0);
    chk("R1", "cas_n", cas_n, 1);
    chk("R1", "we_n", we_n, 1);
    chk("R1", "alatch_n", alatch_n, 1);
    for (int i = 1; i <= 4; i++) begin
      step();
      chk("R1", "phase seq", phase, i % 4);
    end
  endtask

  task automatic t_write_basic();
    load_addr(16'h0100);
    to_phase(2);
    host_sel = 1; host_wr = 1; host_auto = 0; host_wdata = 16'hBEEF;
    step();
    chk("R6", "ddin at accept", ddin, 1);
    chk("R2", "cas_n before Q1", cas_n, 1);
    step();
    chk("R2", "cas_n Q1", cas_n, 0);
    chk("R2", "alatch_n Q1", alatch_n, 0);
    chk("R4", "hoe_n write", hoe_n, 0);
    chk("R3", "rdy Q1", host_rdy, 0);
    chk("R3", "we_n Q1", we_n, 1);
    step();
    chk("R3", "rdy Q2", host_rdy, 1);
    chk("R3", "we_n Q2", we_n, 0);
    chk("R3", "wdata", mem_wdata, 16'hBEEF);
    drop();
    step();
    chk("R7", "rdy after drop", host_rdy, 0);
    chk("R6", "ddin Q3", ddin, 1);
    chk("R3", "we_n Q3", we_n, 0);
    step();
    chk("R4", "cas_n Q4", cas_n, 1);
    chk("R4", "hoe_n Q4", hoe_n, 1);
    chk("R4", "we_n Q4", we_n, 1);
    chk("R6", "ddin Q4", ddin, 0);
    chk("R8", "addr no auto", mem_addr, 16'h0100);
  endtask

  task automatic t_late();
    to_phase(3);
    host_sel = 1; host_wr = 1; host_wdata = 16'h1234;
    step();
    chk("R2", "late not taken", cas_n, 1);
    step(); step(); step();
    chk("R2", "late accepted", ddin, 1);
    step();
    chk("R2", "late cycle Q1", cas_n, 0);
    step();
    chk("R3", "late rdy", host_rdy, 1);
    drop();
    step(); step();
  endtask

  task automatic t_hold();
    to_phase(2);
    host_sel = 1; host_wr = 1; host_wdata = 16'h7777;
    step(); step(); step();
    chk("R7", "hold rdy", host_rdy, 1);
    step(); step(); step();
    chk("R7", "held one access", cas_n, 1);
    chk("R7", "hold rdy kept", host_rdy, 1);
    for (int i = 0; i < 4; i++) step();
    chk("R7", "held one access later", cas_n, 1);
    drop();
    step();
    chk("R7", "rdy falls", host_rdy, 0);
    step(); step();
  endtask

  task automatic t_stall();
    to_phase(2);
    host_sel = 1; host_wr = 1; host_wdata = 16'hAAAA;
    step(); step(); step();
    chk("R5", "first rdy", host_rdy, 1);
    drop();
    step();
    host_sel = 1; host_wr = 1; host_wdata = 16'h5555;
    chk("R5", "no rdy in Q3", host_rdy, 0);
    step();
    chk("R5", "no rdy in Q4", host_rdy, 0);
    step();
    chk("R5", "second cycle Q1", cas_n, 0);
    chk("R5", "no rdy in Q1", host_rdy, 0);
    step();
    chk("R5", "second rdy", host_rdy, 1);
    chk("R5", "second word", mem_wdata, 16'h5555);
    drop();
    step(); step();
  endtask

  task automatic t_prefetch();
    load_addr(16'h0200);
    to_phase(2);
    host_sel = 1; host_wr = 1; host_auto = 1; host_wdata = 16'hC0DE;
    step(); step(); step();
    chk("R3", "auto rdy", host_rdy, 1);
    drop(); host_auto = 0;
    step(); step();
    chk("R8", "addr incremented", mem_addr, 16'h0201);
    step();
    chk("R9", "pf cas_n", cas_n, 0);
    chk("R9", "pf hoe_n", hoe_n, 1);
    chk("R9", "pf we_n", we_n, 1);
    chk("R9", "pf ddin", ddin, 0);
    step(); step();
    chk("R9", "pf no rdy", host_rdy, 0);
    step();
    chk("R9", "pf cas_n end", cas_n, 1);
    chk("R9", "pf data", host_rdata, 16'h0201 ^ 16'h5A5A);
    chk("R9", "pf addr kept", mem_addr, 16'h0201);
  endtask

  task automatic t_read();
    to_phase(2);
    host_sel = 1; host_rd = 1; host_auto = 1;
    step();
    chk("R10", "read ddin", ddin, 0);
    step();
    chk("R10", "read cas_n", cas_n, 0);
    chk("R10", "read hoe_n", hoe_n, 1);
    step();
    chk("R10", "read rdy Q2", host_rdy, 0);
    step();
    step();
    chk("R10", "read rdy Q4", host_rdy, 1);
    chk("R10", "read data", host_rdata, 16'h0201 ^ 16'h5A5A);
    chk("R10", "read addr inc", mem_addr, 16'h0202);
    drop(); host_auto = 0;
    step();
    chk("R10", "read rdy drop", host_rdy, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_basic();
    t_late();
    t_hold();
    t_stall();
    t_prefetch();
    t_read();
    repeat (4) step();
    finish_run();
  end
endmodule